// File: doc/BRIEF.md
# Instruction TLB replacement-order tracker

This block keeps the use order of a four-entry, fully associative instruction TLB. The order lives in one 6-bit word. Each bit records, for one pair of entries, which of the two was touched more recently. When the fetch side reports a hit on an entry, fixed bits of the word are set and cleared for that entry. When a translation is copied in from the unified TLB, the tracker picks the least recently used slot, reports it as the refill target, and then marks that slot as most recently used.

The victim is decoded straight from the order word by matching four bit patterns. At most one of the patterns can match. If none matches, the word was loaded with a contradictory order, and a flag reports it. Software can load the word directly, for example after invalidating the TLB. The tag compare, the entry storage and the page data are handled elsewhere.

Top module: `itlb_lru_tracker`

## Requirements
- R1: Reset is synchronous and active high. During and after reset the order word is 6'b000000, the victim index is 3 and the invalid flag is 0.
- R2: A hit strobe with index k, with no refill and no software write in that cycle, changes the order word on the next clock edge. Each target bit position in the table below is forced; all other bits keep their value.

  | Index k | Bits set | Bits cleared |
  |---|---|---|
  | 0 | none | 5, 4, 3 |
  | 1 | 5 | 2, 1 |
  | 2 | 4, 2 | 0 |
  | 3 | 3, 1, 0 | none |

- R3: The victim index is a combinational decode of the current order word.

  | Victim | Condition on the order word |
  |---|---|
  | 0 | bits 5, 4 and 3 are all 1 |
  | 1 | bit 5 is 0, and bits 2 and 1 are both 1 |
  | 2 | bits 4 and 2 are 0, and bit 0 is 1 |
  | 3 | bits 3, 1 and 0 are all 0 |

- R4: When no pattern of R3 matches, invalid_lru is 1 and the victim index is 0. When a pattern matches, invalid_lru is 0.
- R5: A refill strobe while invalid_lru is 0 applies the R2 update for the current victim index on the next clock edge.
- R6: When refill and hit strobes arrive in the same cycle, only the refill update is applied and the hit is ignored.
- R7: A software write loads the order word with the write data on the next clock edge. It takes precedence over any hit or refill update in the same cycle.
- R8: A refill strobe while invalid_lru is 1, with no software write in that cycle, leaves the order word unchanged.
- R9: In a cycle with no strobe, the order word holds its value.
- R10: After the four entries are used once each in some order, starting from any valid order word, the victim is the first entry of that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | A translation hit on entry hit_idx this cycle |
| hit_idx | input | 2 | Index of the entry that hit |
| refill_valid | input | 1 | The entry named by victim_idx is being refilled this cycle |
| sw_wr_en | input | 1 | Software load of the order word |
| sw_wr_data | input | 6 | Value for the software load |
| lru_state | output | 6 | Current order word |
| victim_idx | output | 2 | Entry to replace on the next refill |
| invalid_lru | output | 1 | The order word matches no victim pattern |

## Verification
The bench loads all 64 order words through the software port and checks the victim decode and invalid flag for each. A decoder with a swapped polarity, or with the wrong priority on unmatched words, shows up as a wrong index or a missing flag. It then refills from every one of those words: a design that updates on a contradictory word, or that uses a stale victim, ends with a word that differs from the expected one. Collisions are exercised directly: refill together with hit, and a software write together with either strobe. A wrong precedence leaves the hit's mask or the update in the word. The bench also plays whole permutations of uses and checks that the oldest entry becomes the victim. An update mask that touches the wrong pair bit breaks this.

// File: rtl/itlb_lru_pkg.sv
`timescale 1ns/1ps
package itlb_lru_pkg;

    localparam int unsigned LRU_ENTRIES = 4;
    localparam int unsigned LRU_IDX_W   = $clog2(LRU_ENTRIES);
    localparam int unsigned LRU_BITS    = LRU_ENTRIES * (LRU_ENTRIES - 1) / 2;

    typedef logic [LRU_BITS-1:0]  lru_vec_t;
    typedef logic [LRU_IDX_W-1:0] lru_idx_t;

    // bits forced to one / forced to zero when an entry is used
    typedef struct packed {
        lru_vec_t set_bits;
        lru_vec_t clr_bits;
    } lru_mask_t;

    // victim pattern: bits that matter and the value they must hold
    typedef struct packed {
        lru_vec_t care;
        lru_vec_t want;
    } lru_rule_t;

    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_HIT    = 2'd1,
        SRC_REFILL = 2'd2,
        SRC_SOFT   = 2'd3
    } lru_src_e;

    typedef struct packed {
        lru_src_e src;
        lru_idx_t idx;
    } lru_sel_t;

    function automatic lru_mask_t use_mask(input lru_idx_t idx);
        lru_mask_t m;
        m = '0;
        case (idx)
            2'd0: m.clr_bits = 6'b111000;
            2'd1: begin
                m.set_bits = 6'b100000;
                m.clr_bits = 6'b000110;
            end
            2'd2: begin
                m.set_bits = 6'b010100;
                m.clr_bits = 6'b000001;
            end
            default: m.set_bits = 6'b001011;
        endcase
        return m;
    endfunction

    function automatic lru_rule_t victim_rule(input lru_idx_t idx);
        lru_rule_t r;
        case (idx)
            2'd0:    r = '{care: 6'b111000, want: 6'b111000};
            2'd1:    r = '{care: 6'b100110, want: 6'b000110};
            2'd2:    r = '{care: 6'b010101, want: 6'b000001};
            default: r = '{care: 6'b001011, want: 6'b000000};
        endcase
        return r;
    endfunction

    function automatic lru_vec_t apply_mask(input lru_vec_t v, input lru_mask_t m);
        return (v & ~m.clr_bits) | m.set_bits;
    endfunction

endpackage

// File: rtl/itlb_lru_victim.sv
`timescale 1ns/1ps
module itlb_lru_victim
    import itlb_lru_pkg::*;
#(
    parameter int unsigned N = LRU_ENTRIES
) (
    input  lru_vec_t state,
    output lru_idx_t victim,
    output logic     invalid
);

    logic [N-1:0] match;

    for (genvar g = 0; g < N; g++) begin : g_rule
        localparam lru_rule_t RULE = victim_rule(lru_idx_t'(g));
        assign match[g] = ((state & RULE.care) == RULE.want);
    end

    // lowest matching index wins; the rules are mutually exclusive anyway
    always_comb begin
        victim  = '0;
        invalid = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                victim  = lru_idx_t'(i);
                invalid = 1'b0;
            end
        end
    end

endmodule

// File: rtl/itlb_lru_ctrl.sv
`timescale 1ns/1ps
module itlb_lru_ctrl
    import itlb_lru_pkg::*;
(
    input  logic     hit_valid,
    input  lru_idx_t hit_idx,
    input  logic     refill_valid,
    input  logic     sw_wr_en,
    input  lru_idx_t victim,
    input  logic     invalid,
    output lru_sel_t sel
);

    // precedence: software load, then refill, then hit
    always_comb begin
        sel.src = SRC_HOLD;
        sel.idx = hit_idx;
        if (sw_wr_en) begin
            sel.src = SRC_SOFT;
        end else if (refill_valid) begin
            sel.idx = victim;
            sel.src = invalid ? SRC_HOLD : SRC_REFILL;
        end else if (hit_valid) begin
            sel.src = SRC_HIT;
        end
    end

endmodule

// File: rtl/itlb_lru_update.sv
`timescale 1ns/1ps
module itlb_lru_update
    import itlb_lru_pkg::*;
#(
    parameter int unsigned N = LRU_ENTRIES
) (
    input  lru_vec_t state,
    input  lru_sel_t sel,
    input  lru_vec_t sw_data,
    output lru_vec_t next_state
);

    lru_vec_t cand [N];

    for (genvar g = 0; g < N; g++) begin : g_cand
        localparam lru_mask_t MASK = use_mask(lru_idx_t'(g));
        assign cand[g] = apply_mask(state, MASK);
    end

    always_comb begin
        unique case (sel.src)
            SRC_SOFT:            next_state = sw_data;
            SRC_HIT, SRC_REFILL: next_state = cand[sel.idx];
            default:             next_state = state;
        endcase
    end

endmodule

// File: rtl/itlb_lru_tracker.sv
`timescale 1ns/1ps
module itlb_lru_tracker
    import itlb_lru_pkg::*;
#(
    parameter int unsigned ENTRIES = LRU_ENTRIES,
    localparam int unsigned IDX_W  = $clog2(ENTRIES),
    localparam int unsigned BITS   = ENTRIES * (ENTRIES - 1) / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_valid,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             refill_valid,
    input  logic             sw_wr_en,
    input  logic [BITS-1:0]  sw_wr_data,
    output logic [BITS-1:0]  lru_state,
    output logic [IDX_W-1:0] victim_idx,
    output logic             invalid_lru
);

    lru_vec_t state_q;
    lru_vec_t state_d;
    lru_idx_t victim;
    logic     invalid;
    lru_sel_t sel;

    itlb_lru_victim #(.N(ENTRIES)) u_victim (
        .state   (state_q),
        .victim  (victim),
        .invalid (invalid)
    );

    itlb_lru_ctrl u_ctrl (
        .hit_valid    (hit_valid),
        .hit_idx      (hit_idx),
        .refill_valid (refill_valid),
        .sw_wr_en     (sw_wr_en),
        .victim       (victim),
        .invalid      (invalid),
        .sel          (sel)
    );

    itlb_lru_update #(.N(ENTRIES)) u_update (
        .state      (state_q),
        .sel        (sel),
        .sw_data    (sw_wr_data),
        .next_state (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign lru_state   = state_q;
    assign victim_idx  = victim;
    assign invalid_lru = invalid;

endmodule

module itlb_lru_checker (
    input logic       clk,
    input logic       rst,
    input logic       hit_valid,
    input logic [1:0] hit_idx,
    input logic       refill_valid,
    input logic       sw_wr_en,
    input logic [5:0] sw_wr_data,
    input logic [5:0] lru_state,
    input logic [1:0] victim_idx,
    input logic       invalid_lru
);

    AST_HIT0_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && !refill_valid && !sw_wr_en && hit_idx == 2'd0)
        |=> (lru_state[5:3] == 3'b000 && lru_state[2:0] == $past(lru_state[2:0]))); // R2

    AST_HIT3_SETS: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && !refill_valid && !sw_wr_en && hit_idx == 2'd3)
        |=> (lru_state[3] && lru_state[1] && lru_state[0])); // R2

    AST_INVALID_VICTIM: assert property (@(posedge clk) disable iff (rst)
        invalid_lru |-> (victim_idx == 2'd0)); // R4

    AST_REFILL_MOVES: assert property (@(posedge clk) disable iff (rst)
        (refill_valid && !invalid_lru && !sw_wr_en)
        |=> (victim_idx != $past(victim_idx) || invalid_lru)); // R5

    AST_SOFT_LOAD: assert property (@(posedge clk) disable iff (rst)
        sw_wr_en |=> (lru_state == $past(sw_wr_data))); // R7

    AST_REFILL_INVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (refill_valid && invalid_lru && !sw_wr_en) |=> $stable(lru_state)); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!hit_valid && !refill_valid && !sw_wr_en) |=> $stable(lru_state)); // R9

endmodule

bind itlb_lru_tracker itlb_lru_checker i_chk (
    .clk          (clk),
    .rst          (rst),
    .hit_valid    (hit_valid),
    .hit_idx      (hit_idx),
    .refill_valid (refill_valid),
    .sw_wr_en     (sw_wr_en),
    .sw_wr_data   (sw_wr_data),
    .lru_state    (lru_state),
    .victim_idx   (victim_idx),
    .invalid_lru  (invalid_lru)
);

// File: tb/test_itlb_lru_tracker.sv
`timescale 1ns/1ps
module test_itlb_lru_tracker;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hit_valid = 1'b0;
    logic [1:0] hit_idx = 2'd0;
    logic       refill_valid = 1'b0;
    logic       sw_wr_en = 1'b0;
    logic [5:0] sw_wr_data = 6'd0;
    logic [5:0] lru_state;
    logic [1:0] victim_idx;
    logic       invalid_lru;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    logic [5:0] mdl = 6'd0;

    typedef struct {
        logic [5:0] st;
        logic [1:0] vic;
        logic       inv;
        int         due;
        string      req;
    } exp_t;
    exp_t q[$];

    itlb_lru_tracker i_itlb_lru_tracker (
        .clk          (clk),
        .rst          (rst),
        .hit_valid    (hit_valid),
        .hit_idx      (hit_idx),
        .refill_valid (refill_valid),
        .sw_wr_en     (sw_wr_en),
        .sw_wr_data   (sw_wr_data),
        .lru_state    (lru_state),
        .victim_idx   (victim_idx),
        .invalid_lru  (invalid_lru)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // model taken from the requirement tables
    function automatic logic [5:0] m_use(input logic [5:0] s, input logic [1:0] k);
        case (k)
            2'd0: return s & 6'b000111;
            2'd1: return (s | 6'b100000) & 6'b111001;
            2'd2: return (s | 6'b010100) & 6'b111110;
            default: return s | 6'b001011;
        endcase
    endfunction

    function automatic logic [2:0] m_vict(input logic [5:0] s);
        if (s[5] && s[4] && s[3])        return 3'b000;
        if (!s[5] && s[2] && s[1])       return 3'b001;
        if (!s[4] && !s[2] && s[0])      return 3'b010;
        if (!s[3] && !s[1] && !s[0])     return 3'b011;
        return 3'b100;  // {invalid, index}
    endfunction

    task automatic compare(input logic [5:0] st, input string req);
        logic [2:0] v;
        v = m_vict(st);
        checks++;
        if (lru_state !== st || victim_idx !== v[1:0] || invalid_lru !== v[2]) begin
            errors++;
            $display("FAIL %s: state=%b victim=%0d invalid=%b, expected state=%b victim=%0d invalid=%b",
                     req, lru_state, victim_idx, invalid_lru, st, v[1:0], v[2]);
        end
    endtask

    // monitor: pops expected items when their cycle arrives
    always @(negedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            compare(e.st, e.req);
        end
    end

    // driver: applies one cycle of stimulus and queues the expected result
    task automatic step(input logic h, input logic [1:0] hi, input logic r,
                        input logic w, input logic [5:0] d, input string req);
        logic [5:0] nxt;
        logic [2:0] v;
        exp_t e;
        @(negedge clk);
        hit_valid = h; hit_idx = hi; refill_valid = r; sw_wr_en = w; sw_wr_data = d;
        v = m_vict(mdl);
        if (w)               nxt = d;
        else if (r && !v[2]) nxt = m_use(mdl, v[1:0]);
        else if (r)          nxt = mdl;
        else if (h)          nxt = m_use(mdl, hi);
        else                 nxt = mdl;
        mdl = nxt;
        e.st = nxt; e.vic = m_vict(nxt); e.inv = e.vic[2]; e.due = cyc + 1; e.req = req;
        q.push_back(e);
    endtask

    task automatic idle(input string req);
        step(1'b0, 2'd0, 1'b0, 1'b0, 6'd0, req);
    endtask

    task automatic hit(input logic [1:0] k, input string req);
        step(1'b1, k, 1'b0, 1'b0, 6'd0, req);
    endtask

    task automatic load(input logic [5:0] d, input string req);
        step(1'b0, 2'd0, 1'b0, 1'b1, d, req);
    endtask

    task automatic perm(input logic [1:0] a, input logic [1:0] b,
                        input logic [1:0] c, input logic [1:0] d);
        hit(a, "R2"); hit(b, "R2"); hit(c, "R2"); hit(d, "R2");
        idle("R9");
        #2;
        checks++;
        if (victim_idx !== a || invalid_lru !== 1'b0) begin
            errors++;
            $display("FAIL R10: victim=%0d invalid=%b, expected victim=%0d invalid=0",
                     victim_idx, invalid_lru, a);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        compare(6'b000000, "R1 reset held");
        @(negedge clk);
        rst = 1'b0;
        #2;
        compare(6'b000000, "R1 after reset");

        // R2: each index from all-zero and all-one words
        for (int k = 0; k < 4; k++) begin
            load(6'b000000, "R7"); hit(2'(k), "R2 from zeros");
            load(6'b111111, "R7"); hit(2'(k), "R2 from ones");
        end

        // R9: idle holds
        load(6'b101001, "R7");
        idle("R9"); idle("R9");

        // R10: permutations of use
        load(6'b000000, "R7");
        perm(2'd0, 2'd1, 2'd2, 2'd3);
        perm(2'd2, 2'd0, 2'd3, 2'd1);
        perm(2'd3, 2'd2, 2'd1, 2'd0);
        perm(2'd1, 2'd3, 2'd0, 2'd2);

        // R3 / R4: every word, then a refill from it (R5 / R8)
        for (int v = 0; v < 64; v++) begin
            load(6'(v), "R3 R4 decode");
            step(1'b0, 2'd0, 1'b1, 1'b0, 6'd0, "R5 R8 refill");
        end

        // R6: refill together with hit
        load(6'b000000, "R7");
        step(1'b1, 2'd0, 1'b1, 1'b0, 6'd0, "R6 refill+hit0");
        step(1'b1, 2'd3, 1'b1, 1'b0, 6'd0, "R6 refill+hit3");

        // R7: software write beats hit and refill
        step(1'b1, 2'd1, 1'b0, 1'b1, 6'b010101, "R7 write+hit");
        step(1'b0, 2'd0, 1'b1, 1'b1, 6'b111000, "R7 write+refill");
        step(1'b1, 2'd2, 1'b1, 1'b1, 6'b000010, "R7 write+both");

        // R8: repeated refills on an invalid word
        step(1'b0, 2'd0, 1'b1, 1'b0, 6'd0, "R8");
        step(1'b1, 2'd1, 1'b1, 1'b0, 6'd0, "R8 with hit");
        idle("R9");
        idle("R9");
        repeat (2) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule